// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 memory from power-on to a programmed, usable state. After reset it owns the memory command bus. It keeps clock enable low and drives no-operation commands for a long settling time. It then raises clock enable and walks a fixed list of commands: precharges, refreshes and mode-register writes. It finishes by raising a completion flag. From that point the main command scheduler takes over the bus, and this block only drives idle commands.

Every delay is a parameter counted in controller clock cycles, so the same logic serves any clock rate. The operating fields written to the main mode register are also parameters: burst length, burst ordering, read latency and write recovery. Chip select is held active throughout. Each command lasts exactly one cycle, and the cycles between commands carry no-operation commands.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst` is high, `mem_cke` is 0, the command pins read no-operation (RAS#/CAS#/WE# = 111), `init_done` is 0 and `mem_cs_n` is 0.
- R2: After `rst` falls, `mem_cke` stays 0 for exactly `T_POWERUP` cycles with no command other than no-operation. It then rises and stays 1 until the next reset.
- R3: The first command is a precharge-all: RAS#/CAS#/WE# = 010 with address bit 10 set. It appears exactly `T_CKE_STAB` cycles after `mem_cke` rises.
- R4: Commands are encoded on {RAS#, CAS#, WE#} as follows: mode write 000, refresh 001, precharge 010, activate 011, write 100, read 101, no-operation 111.
- R5: After the first precharge come four mode writes, in this order:
  - bank 2 with address 0;
  - bank 3 with address 0;
  - bank 1 with address 0, which leaves the DLL enabled, with additive latency 0;
  - bank 0 carrying the operating fields with address bit 8 (DLL reset) set.
- R6: Next come a precharge-all (address bit 10 set), two refreshes, and a bank-0 mode write carrying the operating fields with bit 8 clear.
- R7: The operating fields are placed as follows:
  - bits 2:0 hold the burst length (010 = 4, 011 = 8);
  - bit 3 holds the burst ordering (1 = interleaved);
  - bits 6:4 hold the read latency in cycles (3 to 5);
  - bits 11:9 hold the write recovery minus 1;
  - bit 7 and bits above 11 are 0.
- R8: `T_OCD_GAP` cycles after the final bank-0 write, a bank-1 write with bits 9:7 = 111 is issued. `T_MRD` cycles later, a bank-1 write with bits 9:7 = 000 (and address 0) follows.
- R9: Each command follows the previous one by exactly its gap, with every gap at least 2:
  - `T_RP` after a precharge;
  - `T_RFC` after a refresh;
  - `T_MRD` after a mode write, except the final bank-0 write.
- R10: Every command lasts exactly one cycle, the sequence has exactly eleven commands, and `mem_cs_n` is always 0.
- R11: `init_done` rises `T_MRD` cycles after the last command and holds until reset. Once it is set, only no-operation is driven, with `mem_cke` high.
- R12: A reset in the middle of the sequence returns the block to the R1 state, and the full sequence restarts from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_cke | output | 1 | Memory clock enable |
| mem_cs_n | output | 1 | Chip select, held active low |
| mem_ras_n | output | 1 | Row strobe command pin |
| mem_cas_n | output | 1 | Column strobe command pin |
| mem_we_n | output | 1 | Write enable command pin |
| mem_ba | output | BA_W | Bank select |
| mem_addr | output | ADDR_W | Row/column address and mode field value |
| init_done | output | 1 | Sequence complete, level held |

## Verification
The assertions check the following properties on every cycle:
- clock enable never falls once it is high;
- a command never appears while clock enable is low;
- every command is one cycle wide and no closer than the smallest gap to the previous one;
- the first command is a precharge-all;
- completion is sticky and quiet.

Only the bench scenarios can show the following:
- the exact order of the eleven commands;
- their bank and address values, including the mode fields computed from two different parameter sets;
- the exact cycle distances, including the long gap before the off-chip-driver pair;
- the restart after a mid-sequence reset.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    typedef enum logic [2:0] {
        CMD_LMR = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_ACT = 3'b011,
        CMD_WR  = 3'b100,
        CMD_RD  = 3'b101,
        CMD_NOP = 3'b111
    } mem_cmd_e;

    typedef enum logic [1:0] {
        PH_POWER,
        PH_STAB,
        PH_GAP,
        PH_DONE
    } init_phase_e;

    localparam int NUM_STEPS = 11;
    localparam int STEP_W    = 4;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr2_init_steps.sv
module ddr2_init_steps
    import ddr2_init_pkg::*;
#(
    parameter int ADDR_W           = 14,
    parameter int BA_W             = 2,
    parameter int CNT_W            = 16,
    parameter int BURST_LEN        = 8,
    parameter int CAS_LAT          = 4,
    parameter int WRITE_REC        = 4,
    parameter int BURST_INTERLEAVE = 0,
    parameter int T_RP             = 3,
    parameter int T_RFC            = 16,
    parameter int T_MRD            = 2,
    parameter int T_OCD_GAP        = 200
) (
    input  logic [STEP_W-1:0] step_idx,
    output mem_cmd_e          step_cmd,
    output logic [BA_W-1:0]   step_ba,
    output logic [ADDR_W-1:0] step_addr,
    output logic [CNT_W-1:0]  step_gap
);
    localparam logic [2:0] BL_CODE = (BURST_LEN == 8) ? 3'b011 : 3'b010;
    localparam logic [2:0] CL_CODE = 3'(CAS_LAT);
    localparam logic [2:0] WR_CODE = 3'(WRITE_REC - 1);
    localparam logic       BT_BIT  = 1'(BURST_INTERLEAVE);

    // operating fields of the main mode register, DLL reset clear
    localparam logic [ADDR_W-1:0] MR_OPS =
        {{(ADDR_W-12){1'b0}}, WR_CODE, 2'b00, CL_CODE, BT_BIT, BL_CODE};
    localparam logic [ADDR_W-1:0] DLL_RST_BIT = {{(ADDR_W-9){1'b0}}, 1'b1, 8'b0};
    localparam logic [ADDR_W-1:0] ALL_BANKS   = {{(ADDR_W-11){1'b0}}, 1'b1, 10'b0};
    localparam logic [ADDR_W-1:0] OCD_DEFAULT = {{(ADDR_W-10){1'b0}}, 3'b111, 7'b0};

    localparam logic [CNT_W-1:0] G_RP  = CNT_W'(imax(T_RP, 2));
    localparam logic [CNT_W-1:0] G_RFC = CNT_W'(imax(T_RFC, 2));
    localparam logic [CNT_W-1:0] G_MRD = CNT_W'(imax(T_MRD, 2));
    localparam logic [CNT_W-1:0] G_OCD = CNT_W'(imax(imax(T_OCD_GAP, T_MRD), 2));

    always_comb begin
        step_cmd  = CMD_NOP;
        step_ba   = '0;
        step_addr = '0;
        step_gap  = G_MRD;
        case (step_idx)
            4'd0: begin step_cmd = CMD_PRE; step_addr = ALL_BANKS; step_gap = G_RP; end
            4'd1: begin step_cmd = CMD_LMR; step_ba = BA_W'(2); end
            4'd2: begin step_cmd = CMD_LMR; step_ba = BA_W'(3); end
            4'd3: begin step_cmd = CMD_LMR; step_ba = BA_W'(1); end
            4'd4: begin step_cmd = CMD_LMR; step_addr = MR_OPS | DLL_RST_BIT; end
            4'd5: begin step_cmd = CMD_PRE; step_addr = ALL_BANKS; step_gap = G_RP; end
            4'd6: begin step_cmd = CMD_REF; step_gap = G_RFC; end
            4'd7: begin step_cmd = CMD_REF; step_gap = G_RFC; end
            4'd8: begin step_cmd = CMD_LMR; step_addr = MR_OPS; step_gap = G_OCD; end
            4'd9: begin step_cmd = CMD_LMR; step_ba = BA_W'(1); step_addr = OCD_DEFAULT; end
            4'd10: begin step_cmd = CMD_LMR; step_ba = BA_W'(1); end
            default: ;
        endcase
    end

endmodule

// File: rtl/ddr2_init_pins.sv
module ddr2_init_pins
    import ddr2_init_pkg::*;
(
    input  mem_cmd_e cmd,
    output logic     ras_n,
    output logic     cas_n,
    output logic     we_n
);
    // R4: the three strobe pins carry the command code directly
    always_comb begin
        ras_n = cmd[2];
        cas_n = cmd[1];
        we_n  = cmd[0];
    end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int ADDR_W           = 14,
    parameter int BA_W             = 2,
    parameter int T_POWERUP        = 25000,
    parameter int T_CKE_STAB       = 50,
    parameter int T_RP             = 3,
    parameter int T_RFC            = 16,
    parameter int T_MRD            = 2,
    parameter int T_OCD_GAP        = 200,
    parameter int BURST_LEN        = 8,
    parameter int CAS_LAT          = 4,
    parameter int WRITE_REC        = 4,
    parameter int BURST_INTERLEAVE = 0
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_cke,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [BA_W-1:0]   mem_ba,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              init_done
);
    localparam int MAX_DLY = imax(imax(imax(T_POWERUP, T_CKE_STAB), imax(T_RP, T_RFC)),
                                  imax(imax(T_MRD, T_OCD_GAP), 2));
    localparam int CNT_W   = $clog2(MAX_DLY + 1);
    localparam int MIN_GAP = imax(imin(imin(T_RP, T_RFC), T_MRD), 2);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    typedef struct packed {
        init_phase_e       phase;
        logic [STEP_W-1:0] step;
        logic [CNT_W-1:0]  cnt;
        logic              cke;
        mem_cmd_e          cmd;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
        logic              done;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [STEP_W-1:0] rom_idx;
    mem_cmd_e          rom_cmd;
    logic [BA_W-1:0]   rom_ba;
    logic [ADDR_W-1:0] rom_addr;
    logic [CNT_W-1:0]  rom_gap;

    assign rom_idx = (st_q.phase == PH_GAP) ? st_q.step + 1'b1 : st_q.step;

    ddr2_init_steps #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .CNT_W(CNT_W),
        .BURST_LEN(BURST_LEN), .CAS_LAT(CAS_LAT), .WRITE_REC(WRITE_REC),
        .BURST_INTERLEAVE(BURST_INTERLEAVE),
        .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .T_OCD_GAP(T_OCD_GAP)
    ) u_steps (
        .step_idx (rom_idx),
        .step_cmd (rom_cmd),
        .step_ba  (rom_ba),
        .step_addr(rom_addr),
        .step_gap (rom_gap)
    );

    always_comb begin
        st_d      = st_q;
        st_d.cmd  = CMD_NOP;
        st_d.ba   = '0;
        st_d.addr = '0;
        case (st_q.phase)
            PH_POWER: begin
                if (st_q.cnt == '0) begin
                    st_d.cke   = 1'b1;
                    st_d.phase = PH_STAB;
                    st_d.cnt   = CNT_W'(T_CKE_STAB - 1);
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_STAB, PH_GAP: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end else if (st_q.phase == PH_GAP && st_q.step == LAST_STEP) begin
                    st_d.phase = PH_DONE;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.phase = PH_GAP;
                    st_d.step  = rom_idx;
                    st_d.cmd   = rom_cmd;
                    st_d.ba    = rom_ba;
                    st_d.addr  = rom_addr;
                    st_d.cnt   = rom_gap - 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= PH_POWER;
            st_q.step  <= '0;
            st_q.cnt   <= CNT_W'(T_POWERUP - 1);
            st_q.cke   <= 1'b0;
            st_q.cmd   <= CMD_NOP;
            st_q.ba    <= '0;
            st_q.addr  <= '0;
            st_q.done  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    ddr2_init_pins u_pins (
        .cmd  (st_q.cmd),
        .ras_n(mem_ras_n),
        .cas_n(mem_cas_n),
        .we_n (mem_we_n)
    );

    assign mem_cke   = st_q.cke;
    assign mem_cs_n  = 1'b0;
    assign mem_ba    = st_q.ba;
    assign mem_addr  = st_q.addr;
    assign init_done = st_q.done;

    // ---------------- checks on the driven bus ----------------
    logic [CNT_W-1:0] since_q;
    logic             seen_q;
    mem_cmd_e         pin_cmd;

    assign pin_cmd = mem_cmd_e'({mem_ras_n, mem_cas_n, mem_we_n});

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (pin_cmd != CMD_NOP) begin
            since_q <= CNT_W'(1);
            seen_q  <= 1'b1;
        end else if (since_q != '1) begin
            since_q <= since_q + 1'b1;
        end
    end

    a_r2_cke_stays_high: assert property (@(posedge clk) disable iff (rst)
        mem_cke |=> mem_cke);

    a_r2_no_cmd_while_cke_low: assert property (@(posedge clk) disable iff (rst)
        !mem_cke |-> pin_cmd == CMD_NOP);

    a_r3_first_is_prea: assert property (@(posedge clk) disable iff (rst)
        (pin_cmd != CMD_NOP && !seen_q) |-> (pin_cmd == CMD_PRE && mem_addr[10]));

    a_r9_min_spacing: assert property (@(posedge clk) disable iff (rst)
        (pin_cmd != CMD_NOP && seen_q) |-> since_q >= CNT_W'(MIN_GAP));

    a_r10_single_cycle_cmd: assert property (@(posedge clk) disable iff (rst)
        pin_cmd != CMD_NOP |=> pin_cmd == CMD_NOP);

    a_r11_done_sticky: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    a_r11_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (pin_cmd == CMD_NOP && mem_cke));

endmodule

// File: tb/ddr2_init_seq_test.sv
module ddr2_init_seq_test;
    localparam int P_PWR  = 40;
    localparam int P_STAB = 7;
    localparam int P_RP   = 3;
    localparam int P_RFC  = 9;
    localparam int P_MRD  = 2;
    localparam int P_OCD  = 20;
    localparam int AW     = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          cke, cs_n, ras_n, cas_n, we_n, done;
    logic [1:0]    ba;
    logic [AW-1:0] addr;
    logic          cke2, cs2_n, ras2_n, cas2_n, we2_n, done2;
    logic [1:0]    ba2;
    logic [AW-1:0] addr2;

    ddr2_init_seq #(
        .ADDR_W(AW), .BA_W(2), .T_POWERUP(P_PWR), .T_CKE_STAB(P_STAB),
        .T_RP(P_RP), .T_RFC(P_RFC), .T_MRD(P_MRD), .T_OCD_GAP(P_OCD),
        .BURST_LEN(8), .CAS_LAT(4), .WRITE_REC(3), .BURST_INTERLEAVE(1)
    ) uut (
        .clk(clk), .rst(rst), .mem_cke(cke), .mem_cs_n(cs_n), .mem_ras_n(ras_n),
        .mem_cas_n(cas_n), .mem_we_n(we_n), .mem_ba(ba), .mem_addr(addr),
        .init_done(done)
    );

    ddr2_init_seq #(
        .ADDR_W(AW), .BA_W(2), .T_POWERUP(P_PWR), .T_CKE_STAB(P_STAB),
        .T_RP(P_RP), .T_RFC(P_RFC), .T_MRD(P_MRD), .T_OCD_GAP(P_OCD),
        .BURST_LEN(4), .CAS_LAT(3), .WRITE_REC(6), .BURST_INTERLEAVE(0)
    ) uut_b (
        .clk(clk), .rst(rst), .mem_cke(cke2), .mem_cs_n(cs2_n), .mem_ras_n(ras2_n),
        .mem_cas_n(cas2_n), .mem_we_n(we2_n), .mem_ba(ba2), .mem_addr(addr2),
        .init_done(done2)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int rel_cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // bus recorder
    logic [2:0]    ev_cmd  [16];
    logic [1:0]    ev_ba   [16];
    logic [AW-1:0] ev_addr [16];
    int            ev_cyc  [16];
    int            n_ev, cke_rise, done_at, cs_bad;
    logic [AW-1:0] mr_b [2];
    int            n_mr_b;

    initial cs_bad = 0;
    always @(negedge clk) begin
        if (cs_n !== 1'b0) cs_bad = cs_bad + 1;
        if (rst) begin
            n_ev = 0; cke_rise = -1; done_at = -1; n_mr_b = 0;
        end else begin
            if ({ras_n, cas_n, we_n} != 3'b111) begin
                if (n_ev < 16) begin
                    ev_cmd[n_ev] = {ras_n, cas_n, we_n};
                    ev_ba[n_ev] = ba; ev_addr[n_ev] = addr; ev_cyc[n_ev] = cyc;
                end
                n_ev = n_ev + 1;
            end
            if (cke && cke_rise < 0) cke_rise = cyc;
            if (done && done_at < 0) done_at = cyc;
            if ({ras2_n, cas2_n, we2_n} == 3'b000 && ba2 == 2'd0 && n_mr_b < 2) begin
                mr_b[n_mr_b] = addr2;
                n_mr_b = n_mr_b + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int mr_fields(input int bl, input int cl, input int wr, input int bt);
        return ((bl == 8) ? 3 : 2) | (bt << 3) | (cl << 4) | ((wr - 1) << 9);
    endfunction

    // expected step table from the requirements
    task automatic exp_step(input int i, output int c, output int b, output int a,
                            output int g, output string tg);
        int mr;
        mr = mr_fields(8, 4, 3, 1);
        c = 0; b = 0; a = 0; g = P_MRD; tg = "R5";
        case (i)
            0:  begin c = 2; a = 1 << 10; g = P_RP; tg = "R3"; end
            1:  b = 2;
            2:  b = 3;
            3:  b = 1;
            4:  begin a = mr | (1 << 8); tg = "R7"; end
            5:  begin c = 2; a = 1 << 10; g = P_RP; tg = "R6"; end
            6:  begin c = 1; g = P_RFC; tg = "R6"; end
            7:  begin c = 1; g = P_RFC; tg = "R6"; end
            8:  begin a = mr; g = P_OCD; tg = "R7"; end
            9:  begin b = 1; a = 7 << 7; tg = "R8"; end
            default: begin b = 1; tg = "R8"; end
        endcase
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(cke == 1'b0, "R1 cke in reset", cke, 0);
        chk({ras_n, cas_n, we_n} == 3'b111, "R1 nop in reset", {ras_n, cas_n, we_n}, 7);
        chk(done == 1'b0, "R1 done in reset", done, 0);
        chk(cs_n == 1'b0, "R1 cs_n in reset", cs_n, 0);
        rst = 1'b0;
        rel_cyc = cyc;
    endtask

    task automatic test_powerup();
        while (cke_rise < 0) @(negedge clk);
        chk(cke_rise - rel_cyc == P_PWR, "R2 cke low length", cke_rise - rel_cyc, P_PWR);
        chk(n_ev == 0, "R2 no command before cke", n_ev, 0);
    endtask

    task automatic test_sequence();
        int c, b, a, g;
        string tg;
        while (done_at < 0) @(negedge clk);
        repeat (30) @(negedge clk);
        chk(n_ev == 11, "R10 command count", n_ev, 11);
        chk(cs_bad == 0, "R10 cs_n held low", cs_bad, 0);
        chk(ev_cyc[0] - cke_rise == P_STAB, "R3 first command delay",
            ev_cyc[0] - cke_rise, P_STAB);
        for (int i = 0; i < 11; i++) begin
            exp_step(i, c, b, a, g, tg);
            chk(ev_cmd[i] == 3'(c), $sformatf("R4 step %0d command", i), ev_cmd[i], c);
            chk(ev_ba[i] == 2'(b), $sformatf("%s step %0d bank", tg, i), ev_ba[i], b);
            chk(ev_addr[i] == AW'(a), $sformatf("%s step %0d address", tg, i), ev_addr[i], a);
            if (i < 10)
                chk(ev_cyc[i+1] - ev_cyc[i] == g, $sformatf("R9 gap after step %0d", i),
                    ev_cyc[i+1] - ev_cyc[i], g);
            else
                chk(done_at - ev_cyc[i] == g, "R11 done delay", done_at - ev_cyc[i], g);
        end
        chk(ev_cyc[9] - ev_cyc[8] == P_OCD, "R8 gap before driver default",
            ev_cyc[9] - ev_cyc[8], P_OCD);
        chk(done == 1'b1 && cke == 1'b1, "R11 done and cke held", {done, cke}, 3);
        chk({ras_n, cas_n, we_n} == 3'b111, "R11 idle after done", {ras_n, cas_n, we_n}, 7);
    endtask

    task automatic test_mode_variant();
        int mr;
        mr = mr_fields(4, 3, 6, 0);
        chk(n_mr_b == 2, "R7 variant write count", n_mr_b, 2);
        chk(mr_b[0] == AW'(mr | (1 << 8)), "R7 variant dll reset word", mr_b[0], mr | (1 << 8));
        chk(mr_b[1] == AW'(mr), "R7 variant operating word", mr_b[1], mr);
    endtask

    task automatic test_restart();
        do_reset();
        while (n_ev < 4) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(cke == 1'b0, "R12 cke after mid reset", cke, 0);
        chk(done == 1'b0, "R12 done after mid reset", done, 0);
        chk({ras_n, cas_n, we_n} == 3'b111, "R12 nop after mid reset",
            {ras_n, cas_n, we_n}, 7);
        rst = 1'b0;
        rel_cyc = cyc;
        test_powerup();
        test_sequence();
    endtask

    initial begin
        do_reset();
        test_powerup();
        test_sequence();
        test_mode_variant();
        test_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule